// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block is a one-shot countdown timer. A prescaler divides the block clock by a power of two. Each time the prescaler wraps, a 32-bit count is decremented. Software programs the timer through three registers on a simple write port, with a combinational read port beside it:

- a divide register that selects the prescale ratio;
- a load register that starts the countdown;
- a read-only remaining-count register.

Any write to the load register starts the countdown from the written value. If a countdown is already running, it is thrown away. When the count reaches zero, the block raises an interrupt request for one clock cycle, unless the mask input holds it off. The timer then stays idle until the next load.

The divide ratio comes from three bits of the divide register that are not next to each other: bit 3, bit 1 and bit 0, with bit 3 as the most significant. The ratio is read through a rotated encoding, so the field value seven gives the undivided clock. The remaining-count register reports the time left, rounded up to whole divided counts.

Register select codes on `wr_sel` and `rd_sel`:

| Code | Register |
|------|----------|
| 0 | divide |
| 1 | load |
| 2 | remaining count |
| 3 | reserved, reads as zero |

Top module: `divtmr_top`

## Requirements
- R1: The divide field is {cfg[3], cfg[1], cfg[0]}, with cfg[3] as the most significant bit. The divisor is 2 to the power ((field + 1) mod 8). Field 7 gives 1, field 0 gives 2, field 3 gives 16, field 4 gives 32 and field 6 gives 128.
- R2: A write to the divide register (select 0) stores only bits 3, 1 and 0. A read of select 0 returns the stored value with every other bit zero.
- R3: After a write of N (non-zero) to the load register (select 1) on clock edge t, `irq` is high only in the cycle that follows edge t + N*D, where D is the divisor. `irq` is high for exactly one cycle.
- R4: A load write during a running countdown cancels it. Expiry is then timed from the new write only, and the cancelled countdown raises no interrupt.
- R5: Reading select 2 during a countdown returns ceil(R / D), where R is the number of clock periods left before expiry.
- R6: Select 2 reads as 0 whenever no countdown is active, including after expiry.
- R7: Writes to select 2 have no effect: the remaining count, the expiry time and the divide register are unchanged.
- R8: A load of 0 stops the timer. Select 2 then reads 0 and no interrupt follows.
- R9: When `irq_mask` is high at expiry, no pulse is raised, but the timer still becomes idle.
- R10: A change of the divide register during a countdown takes effect from the next prescaler wrap. The divided count in progress completes at the old ratio.
- R11: Synchronous reset clears the divide register, the count and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the base clock of the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| irq_mask | input | 1 | Suppresses the expiry pulse while high |
| irq | output | 1 | One-cycle expiry request |

## Verification
The assertions assume at most one register write per cycle. The load value is taken as it stands on the write edge. `irq_mask` is treated as a level that matters only on the expiry edge. The bench drives every write and mask change half a period away from the active edge and holds each one for exactly one edge. The bench makes divide changes only on edges where the prescaler is mid-count, so that the edge on which the new ratio applies is unambiguous.

// File: rtl/divtmr_pkg.sv
package divtmr_pkg;
    localparam int TMR_W   = 32;
    localparam int SEL_W   = 2;
    localparam int SHIFT_W = 3;
    localparam int PRE_W   = (1 << SHIFT_W) - 1;

    localparam logic [TMR_W-1:0] DIV_KEEP = TMR_W'(32'h0000_000B);

    typedef enum logic [SEL_W-1:0] {
        SEL_DIV  = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             go;
        logic [TMR_W-1:0] value;
    } load_t;

    // Rotated encoding: the field plus one, wrapping in three bits, is the shift.
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [TMR_W-1:0] cfg);
        logic [SHIFT_W-1:0] field;
        field = {cfg[3], cfg[1], cfg[0]};
        return field + SHIFT_W'(1);
    endfunction
endpackage

// File: rtl/divtmr_regs.sv
module divtmr_regs
    import divtmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [TMR_W-1:0]    wr_data,
    input  logic [SEL_W-1:0]    rd_sel,
    input  logic [TMR_W-1:0]    cur_cnt,
    output logic [SHIFT_W-1:0]  cfg_shift,
    output load_t               load,
    output logic [TMR_W-1:0]    rd_data
);
    logic [TMR_W-1:0] cfg_q;
    logic [TMR_W-1:0] init_q;
    logic             wr_cfg;

    assign wr_cfg = wr_en && (wr_sel == SEL_DIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            init_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_DIV:  cfg_q  <= wr_data & DIV_KEEP;
                SEL_LOAD: init_q <= wr_data;
                default:  ;
            endcase
        end
    end

    assign load.go    = wr_en && (wr_sel == SEL_LOAD);
    assign load.value = wr_data;
    assign cfg_shift  = div_shift(cfg_q);

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_DIV:  rd_data = cfg_q;
            SEL_LOAD: rd_data = init_q;
            SEL_CUR:  rd_data = cur_cnt;
            default:  rd_data = '0;
        endcase
    end

    // R2: only the three field bits survive a divide write
    assert_cfg_masked_R2: assert property (@(posedge clk) disable iff (rst)
        wr_cfg |=> cfg_q == ($past(wr_data) & DIV_KEEP));

    // R7: the divide register moves only on its own write
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_cfg |=> $stable(cfg_q));
endmodule

// File: rtl/divtmr_prescale.sv
module divtmr_prescale
    import divtmr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                active,
    input  logic [SHIFT_W-1:0]  cfg_shift,
    output logic                wrap
);
    logic [PRE_W-1:0]   pre_q;
    logic [SHIFT_W-1:0] shift_act;
    logic [PRE_W-1:0]   lim;

    // Terminal value of the prescaler: divisor minus one.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            lim[i] = (i < int'(shift_act));
        end
    end

    assign wrap = active && !restart && (pre_q == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q     <= '0;
            shift_act <= div_shift('0);
        end else if (restart) begin
            pre_q     <= '0;
            shift_act <= cfg_shift;
        end else if (active) begin
            if (pre_q == lim) begin
                pre_q     <= '0;
                shift_act <= cfg_shift;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    // R1: the prescaler never runs past the active divisor
    assert_pre_bound_R1: assert property (@(posedge clk) disable iff (rst)
        pre_q <= lim);

    // R10: the active ratio is only replaced on a wrap or a restart
    assert_ratio_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !restart) |=> $stable(shift_act));
endmodule

// File: rtl/divtmr_count.sv
module divtmr_count
    import divtmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  load_t              load,
    input  logic               wrap,
    input  logic               irq_mask,
    output logic [TMR_W-1:0]   cnt,
    output logic               active,
    output logic               irq
);
    assign active = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load.go) begin
                cnt <= load.value;
            end else if (wrap) begin
                cnt <= cnt - TMR_W'(1);
                if ((cnt == TMR_W'(1)) && !irq_mask) begin
                    irq <= 1'b1;
                end
            end
        end
    end

    // R3: the expiry request lasts one cycle
    assert_irq_single_R3: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9: a pulse only follows the last count with the mask low
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(cnt) == TMR_W'(1)) && !$past(irq_mask) && !$past(load.go));

    // R8: a zero load leaves the timer idle and quiet
    assert_zero_load_R8: assert property (@(posedge clk) disable iff (rst)
        (load.go && load.value == '0) |=> (cnt == '0) && !irq);

    // R5: without a load the count holds or steps down by one
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        !load.go |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - TMR_W'(1)));
endmodule

// File: rtl/divtmr_top.sv
module divtmr_top
    import divtmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [TMR_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [TMR_W-1:0]   rd_data,
    input  logic               irq_mask,
    output logic               irq
);
    logic [SHIFT_W-1:0] cfg_shift;
    load_t              load;
    logic [TMR_W-1:0]   cnt;
    logic               active;
    logic               wrap;

    divtmr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .cur_cnt   (cnt),
        .cfg_shift (cfg_shift),
        .load      (load),
        .rd_data   (rd_data)
    );

    divtmr_prescale u_pre (
        .clk       (clk),
        .rst       (rst),
        .restart   (load.go),
        .active    (active),
        .cfg_shift (cfg_shift),
        .wrap      (wrap)
    );

    divtmr_count u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .wrap      (wrap),
        .irq_mask  (irq_mask),
        .cnt       (cnt),
        .active    (active),
        .irq       (irq)
    );

    // R6: an idle timer reads back zero and raises nothing
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!active && !load.go) |=> (cnt == '0) && !irq);
endmodule

// File: tb/sim_divtmr_top.sv
module sim_divtmr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_mask = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    divtmr_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_mask(irq_mask), .irq(irq)
    );

    // {divide register value, initial count}
    localparam logic [63:0] VECS [0:6] = '{
        {32'h0000_000B, 32'd7},
        {32'h0000_0000, 32'd5},
        {32'h0000_0003, 32'd5},
        {32'h0000_0008, 32'd2},
        {32'h0000_000A, 32'd3},
        {32'h0000_0001, 32'd3},
        {32'hFFFF_FFF4, 32'd4}
    };

    function automatic int divisor(input logic [31:0] cfg);
        int f;
        f = {cfg[3], cfg[1], cfg[0]};
        return 1 << ((f + 1) % 8);
    endfunction

    function automatic int ceil_div(input int r, input int d);
        return (r + d - 1) / d;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        rd_sel = sel;
        #1;
        data = rd_data;
    endtask

    // Edges until the first pulse (0 if none), and the number of pulse cycles.
    task automatic watch(input int limit, output int first, output int pulses);
        first = 0; pulses = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq) begin
                pulses++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int first, pulses;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        rd(2'd0, v); chk("R11 divide reg after reset", v, 0);
        rd(2'd2, v); chk("R11 count after reset", v, 0);
        chk("R11 irq after reset", irq, 0);
        rd(2'd3, v); chk("R11 reserved reads zero", v, 0);

        // Table walk: R1 R2 R3 R5 R6
        foreach (VECS[j]) begin
            logic [31:0] cfg;
            int n, d, nd, pc;
            cfg = VECS[j][63:32];
            n   = VECS[j][31:0];
            d   = divisor(cfg);
            nd  = n * d;
            wr(2'd0, cfg);
            rd(2'd0, v); chk("R2 divide readback", v, cfg & 32'hB);
            wr(2'd1, n);
            rd(2'd2, v); chk("R5 count right after load", v, n);
            first = 0; pc = 0;
            for (int k = 1; k <= nd + 4; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (irq) begin
                    pc++;
                    if (first == 0) first = k;
                end
                if (k == 1 && nd > 1) begin
                    rd(2'd2, v); chk("R5 count one period in", v, ceil_div(nd - 1, d));
                end
                if (k == nd - 1 && nd > 2) begin
                    rd(2'd2, v); chk("R5 count one period left", v, 1);
                end
            end
            chk("R1 R3 expiry edge", first, nd);
            chk("R3 pulse width", pc, 1);
            rd(2'd2, v); chk("R6 count after expiry", v, 0);
        end

        // R4: restart cancels the running countdown
        wr(2'd0, 32'hB);
        wr(2'd1, 32'd10);
        watch(4, first, pulses);
        chk("R4 no pulse before reload", pulses, 0);
        wr(2'd1, 32'd3);
        watch(20, first, pulses);
        chk("R4 expiry timed from reload", first, 3);
        chk("R4 single pulse after reload", pulses, 1);

        // R7: writes to the remaining-count register are ignored
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd6);
        wr(2'd2, 32'h55);
        rd(2'd2, v); chk("R7 count unchanged by write", v, ceil_div(11, 2));
        rd(2'd0, v); chk("R7 divide reg unchanged", v, 0);
        watch(20, first, pulses);
        chk("R7 expiry unchanged", first + 1, 12);

        // R8: zero load stops the timer
        wr(2'd0, 32'hB);
        wr(2'd1, 32'd10);
        watch(2, first, pulses);
        wr(2'd1, 32'd0);
        rd(2'd2, v); chk("R8 count after zero load", v, 0);
        watch(15, first, pulses);
        chk("R8 no pulse after zero load", pulses, 0);

        // R9: mask suppresses the pulse, timer still idles
        irq_mask = 1'b1;
        wr(2'd1, 32'd3);
        watch(6, first, pulses);
        chk("R9 masked pulse", pulses, 0);
        rd(2'd2, v); chk("R9 idle after masked expiry", v, 0);
        irq_mask = 1'b0;
        watch(3, first, pulses);
        chk("R9 nothing on unmask", pulses, 0);

        // R10: divide change applies at the next wrap
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd4);
        wr(2'd0, 32'hB);
        rd(2'd2, v); chk("R10 count mid first period", v, 4);
        watch(12, first, pulses);
        chk("R10 expiry with late ratio change", first + 1, 5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule